// File: doc/BRIEF.md
# Zoom and Pan Decimation Selector

This block sits in front of a two-dimensional filter datapath and decides, for every input pixel that arrives in raster order, whether that pixel position yields an output pixel. It keeps its own column and row count, starting from a pixel flagged as the first of a frame. A pixel is selected only when it lies inside a rectangular window of the input frame, and within that window only one position per decimation step in each axis is kept. Every input pixel is still consumed and counted, whether selected or not.

The window origin, its size and the two decimation factors arrive on run-time ports. They are copied into shadow registers on the frame-start pixel and hold for the whole frame. A host can therefore move them freely without tearing the picture. Moving the origin pans the view, and changing the size and decimation together zooms it.

For each selected pixel the block raises a one-cycle emit strobe, and it flags the first emit of each frame. It also drives a phase index that a coefficient memory can use as its row address. The phase restarts at every emit and counts the clock cycles available until the next output, up to the product of the two decimation factors and the minimum input interval.

Top module: `zpan_decim_sel`

## Requirements
- R1: While `rst_n` is low, and right after it goes low, `out_emit`, `out_frame` and `out_phase` are 0. After reset no pixel emits until a pixel with both `pix_valid` and `pix_first` high has been seen.
- R2: A pixel with `pix_valid` and `pix_first` high is at column 0, row 0. Each further pixel with `pix_valid` high is one column to the right. After column FRAME_W-1 the count moves to column 0 of the next row, and after the last row it returns to row 0. Cycles with `pix_valid` low do not move the position.
- R3: A pixel at column x, row y can emit only if `org_x` <= x < `org_x`+`span_x` and `org_y` <= y < `org_y`+`span_y`. A window that reaches past the frame is cut at the frame edge and never wraps into the next row.
- R4: Inside the window a pixel emits exactly when (x-`org_x`) is a multiple of `dec_x_m1`+1 and (y-`org_y`) is a multiple of `dec_y_m1`+1. The first emit of a frame is therefore at the window origin, and the column step restarts at the window's left edge on every row.
- R5: The six configuration ports are sampled only on the frame-start pixel. Values they take at any other time have no effect on the current frame.
- R6: `out_frame` is high together with the first emit of a frame and with no other emit.
- R7: `out_emit` and `out_frame` for a pixel rise in the cycle after the clock edge that accepts that pixel.
- R8: `out_phase` is 0 in every cycle with `out_emit` high. In each later cycle it grows by one, and it stops at (`dec_x_m1`+1)*(`dec_y_m1`+1)*MULTI_CYC-1, computed from the configuration in force.
- R9: A window of zero width or zero height produces no emit in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | An input pixel is present this cycle |
| pix_first | input | 1 | The present pixel is column 0, row 0 of a frame |
| org_x | input | clog2(FRAME_W) | Window origin column |
| org_y | input | clog2(FRAME_H) | Window origin row |
| span_x | input | clog2(FRAME_W)+1 | Window width in pixels |
| span_y | input | clog2(FRAME_H)+1 | Window height in rows |
| dec_x_m1 | input | clog2(DEC_MAX) | Column decimation factor minus one |
| dec_y_m1 | input | clog2(DEC_MAX) | Row decimation factor minus one |
| out_emit | output | 1 | The pixel accepted at the previous edge is selected |
| out_frame | output | 1 | This emit is the first of its frame |
| out_phase | output | clog2(DEC_MAX*DEC_MAX*MULTI_CYC+1) | Phase index for the coefficient row |

## Verification
The hardest case to reach is a configuration change that lands exactly on the frame-start pixel while the previous frame's shadow values still govern the phase limit and the row step counter. In every frame the bench applies a new configuration on the frame-start pixel and, from the very next pixel, drives the configuration ports with inverted values for the rest of the frame. Input gaps are spread through the frame, a frame is cut short before a new frame start arrives, and a reset is applied in mid-frame. A cycle-level reference model written with modulo arithmetic then predicts each emit, first-emit flag and phase value.

// File: rtl/dsel_pkg.sv
package dsel_pkg;

  // Number of cycles in one output interval for a given decimation pair.
  function automatic logic [31:0] phase_span(input logic [31:0] dxm1,
                                             input logic [31:0] dym1,
                                             input logic [31:0] mc);
    return (dxm1 + 32'd1) * (dym1 + 32'd1) * mc;
  endfunction

  // Half-open interval test: org <= pos < org + len.
  function automatic logic in_span(input logic [31:0] pos,
                                   input logic [31:0] org,
                                   input logic [31:0] len);
    return (pos >= org) && (pos < org + len);
  endfunction

endpackage

// File: rtl/dsel_cfg_latch.sv
module dsel_cfg_latch #(
  parameter int XW = 4,
  parameter int YW = 4,
  parameter int DW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [XW-1:0] org_x_in,
  input  logic [YW-1:0] org_y_in,
  input  logic [XW:0]   len_x_in,
  input  logic [YW:0]   len_y_in,
  input  logic [DW-1:0] dxm1_in,
  input  logic [DW-1:0] dym1_in,
  output logic [XW-1:0] org_x,
  output logic [YW-1:0] org_y,
  output logic [XW:0]   len_x,
  output logic [YW:0]   len_y,
  output logic [DW-1:0] dxm1,
  output logic [DW-1:0] dym1
);

  logic [XW-1:0] sh_org_x;
  logic [YW-1:0] sh_org_y;
  logic [XW:0]   sh_len_x;
  logic [YW:0]   sh_len_y;
  logic [DW-1:0] sh_dxm1;
  logic [DW-1:0] sh_dym1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_org_x <= '0;
      sh_org_y <= '0;
      sh_len_x <= '0;
      sh_len_y <= '0;
      sh_dxm1  <= '0;
      sh_dym1  <= '0;
    end else if (load) begin
      sh_org_x <= org_x_in;
      sh_org_y <= org_y_in;
      sh_len_x <= len_x_in;
      sh_len_y <= len_y_in;
      sh_dxm1  <= dxm1_in;
      sh_dym1  <= dym1_in;
    end
  end

  // The frame-start pixel itself is judged with the values being loaded.
  always_comb begin
    org_x = load ? org_x_in : sh_org_x;
    org_y = load ? org_y_in : sh_org_y;
    len_x = load ? len_x_in : sh_len_x;
    len_y = load ? len_y_in : sh_len_y;
    dxm1  = load ? dxm1_in  : sh_dxm1;
    dym1  = load ? dym1_in  : sh_dym1;
  end

  // R5: shadow copy moves only on a frame-start pixel
  a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({sh_org_x, sh_org_y, sh_len_x, sh_len_y, sh_dxm1, sh_dym1}));

endmodule

// File: rtl/dsel_raster.sv
module dsel_raster #(
  parameter int FRAME_W = 64,
  parameter int FRAME_H = 48,
  parameter int XW      = 6,
  parameter int YW      = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic          pix_first,
  output logic [XW-1:0] pos_x,
  output logic [YW-1:0] pos_y,
  output logic          frame_start,
  output logic          row_end,
  output logic          locked,
  output logic          armed
);

  localparam logic [XW-1:0] XONE  = XW'(1);
  localparam logic [YW-1:0] YONE  = YW'(1);
  localparam logic [XW-1:0] XLAST = XW'(FRAME_W - 1);
  localparam logic [YW-1:0] YLAST = YW'(FRAME_H - 1);

  logic [XW-1:0] col_q;
  logic [YW-1:0] row_q;
  logic          armed_q;

  assign frame_start = pix_valid & pix_first;
  assign pos_x       = frame_start ? '0 : col_q;
  assign pos_y       = frame_start ? '0 : row_q;
  assign row_end     = pix_valid && (pos_x == XLAST);
  assign locked      = armed_q | frame_start;
  assign armed       = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      row_q   <= '0;
      armed_q <= 1'b0;
    end else if (pix_valid) begin
      if (frame_start) armed_q <= 1'b1;
      if (row_end) begin
        col_q <= '0;
        row_q <= (pos_y == YLAST) ? '0 : pos_y + YONE;
      end else begin
        col_q <= pos_x + XONE;
        row_q <= pos_y;
      end
    end
  end

  // R2: column never leaves the frame
  a_r2_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(col_q) < FRAME_W);

  // R2: an idle cycle leaves the raster position untouched
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> $stable({col_q, row_q}));

endmodule

// File: rtl/dsel_step_ctr.sv
module dsel_step_ctr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  input  logic         restart,
  input  logic [W-1:0] wrap_at,
  output logic [W-1:0] cur,
  output logic         hit
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  assign cur = restart ? '0 : cnt_q;
  assign hit = (cur == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (advance) cnt_q <= (cur == wrap_at) ? '0 : cur + ONE;
  end

  // R4: a step that reaches the factor starts a new decimation interval
  a_r4_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && cur == wrap_at) |=> cnt_q == '0);

endmodule

// File: rtl/dsel_phase.sv
module dsel_phase #(
  parameter int DW        = 3,
  parameter int PW        = 7,
  parameter int MULTI_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [DW-1:0] dxm1,
  input  logic [DW-1:0] dym1,
  output logic [PW-1:0] phase
);
  import dsel_pkg::*;

  localparam logic [PW-1:0] PONE = PW'(1);

  logic [31:0]   lim;
  logic          at_top;
  logic [PW-1:0] phase_q;

  assign lim    = phase_span(32'(dxm1), 32'(dym1), 32'(MULTI_CYC)) - 32'd1;
  assign at_top = 32'(phase_q) >= lim;
  assign phase  = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (clr)     phase_q <= '0;
    else if (!at_top) phase_q <= phase_q + PONE;
  end

  // R8: an emit restarts the phase
  a_r8_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> phase_q == '0);

  // R8: below the limit the phase climbs by one per cycle
  a_r8_phase_climb: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !at_top) |=> phase_q == $past(phase_q) + PONE);

endmodule

// File: rtl/zpan_decim_sel.sv
module zpan_decim_sel #(
  parameter int FRAME_W   = 64,
  parameter int FRAME_H   = 48,
  parameter int DEC_MAX   = 8,
  parameter int MULTI_CYC = 2,
  localparam int XW = $clog2(FRAME_W),
  localparam int YW = $clog2(FRAME_H),
  localparam int DW = (DEC_MAX > 1) ? $clog2(DEC_MAX) : 1,
  localparam int PW = $clog2(DEC_MAX * DEC_MAX * MULTI_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic          pix_first,
  input  logic [XW-1:0] org_x,
  input  logic [YW-1:0] org_y,
  input  logic [XW:0]   span_x,
  input  logic [YW:0]   span_y,
  input  logic [DW-1:0] dec_x_m1,
  input  logic [DW-1:0] dec_y_m1,
  output logic          out_emit,
  output logic          out_frame,
  output logic [PW-1:0] out_phase
);
  import dsel_pkg::*;

  // Configuration in force for the current pixel
  logic [XW-1:0] e_org_x;
  logic [YW-1:0] e_org_y;
  logic [XW:0]   e_len_x;
  logic [YW:0]   e_len_y;
  logic [DW-1:0] e_dxm1;
  logic [DW-1:0] e_dym1;

  // Raster events
  logic [XW-1:0] pos_x;
  logic [YW-1:0] pos_y;
  logic          frame_start;
  logic          row_end;
  logic          locked;
  logic          armed;

  // Decimation events
  logic [DW-1:0] cur_x;
  logic [DW-1:0] cur_y;
  logic          hit_x;
  logic          hit_y;
  logic          in_x;
  logic          in_y;
  logic          emit_nx;
  logic          first_nx;

  logic          emit_q;
  logic          first_q;
  logic          pend_q;

  dsel_cfg_latch #(.XW(XW), .YW(YW), .DW(DW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_start),
    .org_x_in (org_x),
    .org_y_in (org_y),
    .len_x_in (span_x),
    .len_y_in (span_y),
    .dxm1_in  (dec_x_m1),
    .dym1_in  (dec_y_m1),
    .org_x    (e_org_x),
    .org_y    (e_org_y),
    .len_x    (e_len_x),
    .len_y    (e_len_y),
    .dxm1     (e_dxm1),
    .dym1     (e_dym1)
  );

  dsel_raster #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .XW(XW), .YW(YW)) u_raster (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_valid   (pix_valid),
    .pix_first   (pix_first),
    .pos_x       (pos_x),
    .pos_y       (pos_y),
    .frame_start (frame_start),
    .row_end     (row_end),
    .locked      (locked),
    .armed       (armed)
  );

  // Column step: restarts at the window's left edge on every row
  dsel_step_ctr #(.W(DW)) u_step_x (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (pix_valid),
    .restart (pos_x == e_org_x),
    .wrap_at (e_dxm1),
    .cur     (cur_x),
    .hit     (hit_x)
  );

  // Row step: advances once per completed row, restarts on the window's top row
  dsel_step_ctr #(.W(DW)) u_step_y (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (row_end),
    .restart (pos_y == e_org_y),
    .wrap_at (e_dym1),
    .cur     (cur_y),
    .hit     (hit_y)
  );

  // Positions are always inside the frame, so clipping falls out of the span test.
  assign in_x     = in_span(32'(pos_x), 32'(e_org_x), 32'(e_len_x));
  assign in_y     = in_span(32'(pos_y), 32'(e_org_y), 32'(e_len_y));
  assign emit_nx  = pix_valid & locked & in_x & in_y & hit_x & hit_y;
  assign first_nx = emit_nx & (pend_q | frame_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emit_q  <= 1'b0;
      first_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      emit_q  <= emit_nx;
      first_q <= first_nx;
      if (emit_nx)          pend_q <= 1'b0;
      else if (frame_start) pend_q <= 1'b1;
    end
  end

  dsel_phase #(.DW(DW), .PW(PW), .MULTI_CYC(MULTI_CYC)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (emit_nx),
    .dxm1  (e_dxm1),
    .dym1  (e_dym1),
    .phase (out_phase)
  );

  assign out_emit  = emit_q;
  assign out_frame = first_q;

  // R1: nothing is selected before the first frame start after reset
  a_r1_quiet_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !emit_q);

  // R6: the frame flag only ever rides on an emit
  a_r6_flag_on_emit: assert property (@(posedge clk) disable iff (!rst_n)
    first_q |-> emit_q);

  // R8: phase reads zero whenever an emit is presented
  a_r8_zero_at_emit: assert property (@(posedge clk) disable iff (!rst_n)
    emit_q |-> out_phase == '0);

  // R4: a selected pixel sat on both decimation grid points
  a_r4_grid_point: assert property (@(posedge clk) disable iff (!rst_n)
    emit_nx |-> (cur_x == '0 && cur_y == '0));

endmodule

// File: tb/tb_zpan_decim_sel.sv
`timescale 1ns/1ps
module tb_zpan_decim_sel;

  localparam int FW   = 16;
  localparam int FH   = 12;
  localparam int DMAX = 8;
  localparam int MC   = 2;
  localparam int XW   = $clog2(FW);
  localparam int YW   = $clog2(FH);
  localparam int DW   = $clog2(DMAX);
  localparam int PW   = $clog2(DMAX * DMAX * MC + 1);
  localparam int NVEC = 7;

  // Columns: org_x, org_y, span_x, span_y, dec_x_m1, dec_y_m1, expected emits per frame
  localparam int VEC [NVEC][7] = '{
    '{ 0,  0, 16, 12, 0, 0, 192},
    '{ 2,  1,  8,  6, 1, 1,  12},
    '{ 3,  2, 10,  9, 2, 3,  12},
    '{12,  8, 10, 10, 1, 0,   8},
    '{ 5,  5,  0,  4, 0, 0,   0},
    '{ 0,  0, 16, 12, 7, 7,   4},
    '{15, 11,  1,  1, 0, 0,   1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pix_valid = 1'b0;
  logic          pix_first = 1'b0;
  logic [XW-1:0] org_x = '0;
  logic [YW-1:0] org_y = '0;
  logic [XW:0]   span_x = '0;
  logic [YW:0]   span_y = '0;
  logic [DW-1:0] dec_x_m1 = '0;
  logic [DW-1:0] dec_y_m1 = '0;
  logic          out_emit;
  logic          out_frame;
  logic [PW-1:0] out_phase;

  always #2.5 clk = ~clk;

  zpan_decim_sel #(.FRAME_W(FW), .FRAME_H(FH), .DEC_MAX(DMAX), .MULTI_CYC(MC)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_first (pix_first),
    .org_x     (org_x),
    .org_y     (org_y),
    .span_x    (span_x),
    .span_y    (span_y),
    .dec_x_m1  (dec_x_m1),
    .dec_y_m1  (dec_y_m1),
    .out_emit  (out_emit),
    .out_frame (out_frame),
    .out_phase (out_phase)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Reference model state
  int m_x, m_y, m_ox, m_oy, m_w, m_h, m_dx, m_dy, m_phase;
  bit m_armed, m_pend;
  int seen_emit, seen_first;

  task automatic check(input bit ok, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  task automatic model_reset();
    m_x = 0; m_y = 0; m_ox = 0; m_oy = 0; m_w = 0; m_h = 0;
    m_dx = 1; m_dy = 1; m_phase = 0; m_armed = 0; m_pend = 0;
  endtask

  function automatic bit on_grid(input int x, input int y);
    if (!(x >= m_ox && x < m_ox + m_w && y >= m_oy && y < m_oy + m_h)) return 0;
    return ((x - m_ox) % m_dx == 0) && ((y - m_oy) % m_dy == 0);
  endfunction

  // One clock: drive at the falling edge, predict at the rising edge, compare at the next falling edge.
  task automatic step(input bit v, input bit f);
    bit e, ef;
    int n;
    pix_valid = v;
    pix_first = f;
    @(posedge clk);
    e = 0; ef = 0;
    if (v && f) begin
      m_x = 0; m_y = 0; m_armed = 1; m_pend = 1;
      m_ox = int'(org_x); m_oy = int'(org_y); m_w = int'(span_x); m_h = int'(span_y);
      m_dx = int'(dec_x_m1) + 1; m_dy = int'(dec_y_m1) + 1;
    end
    if (v) begin
      if (m_armed && on_grid(m_x, m_y)) begin
        e = 1; ef = m_pend; m_pend = 0;
      end
      m_x++;
      if (m_x == FW) begin
        m_x = 0; m_y++;
        if (m_y == FH) m_y = 0;
      end
    end
    n = m_dx * m_dy * MC;
    if (e) m_phase = 0;
    else if (m_phase < n - 1) m_phase++;
    @(negedge clk);
    check(out_emit == e, "R2 R3 R4 R5 R7 emit per pixel", int'(out_emit), int'(e));
    check(out_frame == ef, "R6 R7 frame flag per pixel", int'(out_frame), int'(ef));
    check(int'(out_phase) == m_phase, "R8 phase per cycle", int'(out_phase), m_phase);
    seen_emit  += int'(out_emit);
    seen_first += int'(out_frame);
  endtask

  task automatic run_frame(input int k, input int npix, input bit score);
    org_x    = XW'(VEC[k][0]);
    org_y    = YW'(VEC[k][1]);
    span_x   = (XW+1)'(VEC[k][2]);
    span_y   = (YW+1)'(VEC[k][3]);
    dec_x_m1 = DW'(VEC[k][4]);
    dec_y_m1 = DW'(VEC[k][5]);
    seen_emit = 0; seen_first = 0;
    step(1, 1);
    // R5: the ports now carry different values for the rest of the frame
    org_x = ~org_x; org_y = ~org_y; span_x = ~span_x; span_y = ~span_y;
    dec_x_m1 = ~dec_x_m1; dec_y_m1 = ~dec_y_m1;
    for (int i = 1; i < npix; i++) begin
      if (i % 9 == 4) step(0, 0);
      step(1, 0);
    end
    if (score) begin
      check(seen_emit == VEC[k][6], "R3 R4 R5 R9 emits per frame", seen_emit, VEC[k][6]);
      check(seen_first == ((VEC[k][6] > 0) ? 1 : 0), "R6 one flag per frame",
            seen_first, (VEC[k][6] > 0) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_emit == 1'b0 && out_frame == 1'b0, "R1 reset outputs", int'(out_emit), 0);
    check(out_phase == '0, "R1 reset phase", int'(out_phase), 0);
    rst_n = 1'b1;

    // R1: pixels before any frame start select nothing
    org_x = '0; org_y = '0; span_x = (XW+1)'(FW); span_y = (YW+1)'(FH);
    seen_emit = 0;
    for (int i = 0; i < 20; i++) step(1, 0);
    check(seen_emit == 0, "R1 no emit before frame start", seen_emit, 0);

    // Table of configurations, one full frame each
    for (int k = 0; k < NVEC; k++) run_frame(k, FW * FH, 1'b1);

    // R2: a frame start in mid-frame restarts the raster
    run_frame(1, 40, 1'b0);
    run_frame(2, FW * FH, 1'b1);

    // R1: reset in mid-frame clears outputs and disarms the block
    run_frame(0, 30, 1'b0);
    rst_n = 1'b0;
    #1;
    check(out_emit == 1'b0 && out_frame == 1'b0, "R1 async reset outputs", int'(out_emit), 0);
    check(out_phase == '0, "R1 async reset phase", int'(out_phase), 0);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    org_x = '0; org_y = '0; span_x = (XW+1)'(FW); span_y = (YW+1)'(FH);
    seen_emit = 0;
    for (int i = 0; i < 12; i++) step(1, 0);
    check(seen_emit == 0, "R1 disarmed after reset", seen_emit, 0);

    // R8: long phase ramp with largest factors, then a normal frame
    run_frame(5, FW * FH, 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule